// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block walks a control store of 30-bit microwords and turns each one into a set of control outputs. Every microword carries three fields. The micro-operation bits drive the datapath. A condition selector names one of eight external status flags. A branch target gives the address to jump to when that flag is set. When the selected flag is 0, the sequencer moves on to the next sequential address.

An instruction decoder starts a routine by pulsing `start` with the routine's entry point on `map_addr`. The control store is written through a preload port. While that port is active the sequencer holds its address. Once writing ends, it spends one cycle re-fetching the microword at the held address and then carries on stepping.

The microword bit layout is fixed, because the decoding depends on it:
- bits [29:15]: the micro-operation field.
- bits [14:12]: the condition selector.
- bits [11:0]: the branch target.

The store holds 4096 words and is read synchronously. The word for an address becomes visible one clock edge after that address is chosen.

Top module: `micro_sequencer`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `car_o` is 0, `valid_o` is 0 and `uop_o` is 0.
- R2: When `valid_o` is 1, `uop_o` equals bits [29:15] of the microword stored at address `car_o`. When `valid_o` is 0, `uop_o` is 0.
- R3: After reset, or after a preload ends, the first cycle without `load_en` or `start` leaves `car_o` unchanged and raises `valid_o`, with `uop_o` taken from the current store contents at `car_o`.
- R4: With `valid_o` 1 and no `start` or `load_en`, the next cycle reads the flag selected by bits [14:12] of the current microword. If that flag is 1, `car_o` takes the value of bits [11:0].
- R5: Under the same conditions as R4, if the selected flag is 0, `car_o` becomes its current value plus 1.
- R6: The sequential step from address 4095 wraps to address 0.
- R7: A `start` pulse without `load_en` sets `car_o` to `map_addr` on the next cycle, with `valid_o` 1 and the micro-operation of that word. `start` takes priority over a branch that would otherwise be taken.
- R8: While `load_en` is high, the word on `load_word` is written at `load_addr`. `car_o` holds its value, `valid_o` drops to 0, and a simultaneous `start` is ignored.
- R9: Flags other than the one selected have no effect on the next address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write `load_word` into the store and stall sequencing |
| load_addr | input | 12 | Store address written during preload |
| load_word | input | 30 | Microword written during preload |
| start | input | 1 | Jump to `map_addr` to begin a routine |
| map_addr | input | 12 | Routine entry address |
| flags | input | 8 | Status flags for conditional branching |
| car_o | output | 12 | Current control address |
| uop_o | output | 15 | Micro-operation control signals |
| valid_o | output | 1 | The buffered microword matches `car_o` |

## Verification
The bench steers one routine through several corner cases:
- A taken branch whose target is the top address, followed by a sequential step that must wrap to 0. A design with an unguarded carry would leave the address range or stay stuck.
- A selected flag held at 0 while every other flag is 1. A design that reduced the whole flag vector would branch wrongly.
- A `start` raised while a branch condition is true. A design with the wrong priority would follow the branch instead of the entry address.
- A preload that rewrites the very word the sequencer is parked on, with `start` also raised. The bench then checks that the priming cycle shows the new contents, not a stale buffer, and that `start` had no effect.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int UOP_W_DEF  = 15;
  localparam int SEL_W_DEF  = 3;
  localparam int ADDR_W_DEF = 12;

  typedef enum logic [1:0] {
    STEP_PRIME  = 2'd0,
    STEP_SEQ    = 2'd1,
    STEP_BRANCH = 2'd2,
    STEP_MAP    = 2'd3
  } step_e;
endpackage

// File: rtl/seq_ctrl_store.sv
module seq_ctrl_store #(
  parameter int WORD_W = 30,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/seq_cond_select.sv
module seq_cond_select #(
  parameter int SEL_W = 3
) (
  input  logic [(1<<SEL_W)-1:0] flags,
  input  logic [SEL_W-1:0]      sel,
  output logic                  hit
);
  localparam int NFLAGS = 1 << SEL_W;

  logic [NFLAGS-1:0] match;

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    assign match[i] = (sel == SEL_W'(i)) && flags[i];
  end

  assign hit = |match;
endmodule

// File: rtl/seq_next_addr.sv
module seq_next_addr
  import seq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] car,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] map_addr,
  input  logic              primed,
  input  logic              start,
  input  logic              taken,
  output logic [ADDR_W-1:0] nxt,
  output step_e             kind
);
  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] a);
    return ADDR_W'(a + ADDR_W'(1));
  endfunction

  function automatic step_e pick(input logic s, input logic p, input logic t);
    if (s)      return STEP_MAP;
    else if (!p) return STEP_PRIME;
    else if (t)  return STEP_BRANCH;
    else         return STEP_SEQ;
  endfunction

  always_comb begin
    kind = pick(start, primed, taken);
    unique case (kind)
      STEP_MAP:    nxt = map_addr;
      STEP_PRIME:  nxt = car;
      STEP_BRANCH: nxt = target;
      default:     nxt = bump(car);
    endcase
  end
endmodule

// File: rtl/micro_sequencer.sv
module micro_sequencer
  import seq_pkg::*;
#(
  parameter int UOP_W  = UOP_W_DEF,
  parameter int SEL_W  = SEL_W_DEF,
  parameter int ADDR_W = ADDR_W_DEF
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_en,
  input  logic [ADDR_W-1:0]         load_addr,
  input  logic [UOP_W+SEL_W+ADDR_W-1:0] load_word,
  input  logic                      start,
  input  logic [ADDR_W-1:0]         map_addr,
  input  logic [(1<<SEL_W)-1:0]     flags,
  output logic [ADDR_W-1:0]         car_o,
  output logic [UOP_W-1:0]          uop_o,
  output logic                      valid_o
);
  localparam int WORD_W  = UOP_W + SEL_W + ADDR_W;
  localparam int UOP_LSB = SEL_W + ADDR_W;

  logic [ADDR_W-1:0] car_q;
  logic              primed_q;
  logic [WORD_W-1:0] mbr;
  logic [ADDR_W-1:0] nxt_w;
  logic [ADDR_W-1:0] target_w;
  logic [SEL_W-1:0]  sel_w;
  logic              taken_w;
  step_e             kind_w;

  assign target_w = mbr[ADDR_W-1:0];
  assign sel_w    = mbr[UOP_LSB-1:ADDR_W];

  seq_ctrl_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
    .clk    (clk),
    .wr_en  (load_en),
    .wr_addr(load_addr),
    .wr_data(load_word),
    .rd_en  (!load_en),
    .rd_addr(nxt_w),
    .rd_data(mbr)
  );

  seq_cond_select #(.SEL_W(SEL_W)) u_cond (
    .flags(flags),
    .sel  (sel_w),
    .hit  (taken_w)
  );

  seq_next_addr #(.ADDR_W(ADDR_W)) u_next (
    .car     (car_q),
    .target  (target_w),
    .map_addr(map_addr),
    .primed  (primed_q),
    .start   (start),
    .taken   (taken_w),
    .nxt     (nxt_w),
    .kind    (kind_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      car_q    <= '0;
      primed_q <= 1'b0;
    end else if (load_en) begin
      primed_q <= 1'b0;
    end else begin
      car_q    <= nxt_w;
      primed_q <= 1'b1;
    end
  end

  assign car_o   = car_q;
  assign valid_o = primed_q;
  assign uop_o   = primed_q ? mbr[WORD_W-1:UOP_LSB] : '0;
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int ADDR_W = 12,
  parameter int UOP_W  = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              load_en,
  input logic              start,
  input logic [ADDR_W-1:0] map_addr,
  input logic [ADDR_W-1:0] car_o,
  input logic [UOP_W-1:0]  uop_o,
  input logic              valid_o,
  input logic              taken_w,
  input logic [ADDR_W-1:0] target_w
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> uop_o == '0);  // R2
  AST_PRIME_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && !start && !load_en) |=> (valid_o && $stable(car_o)));  // R3
  AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !start && !load_en && taken_w) |=> car_o == $past(target_w));  // R4
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !start && !load_en && !taken_w) |=> car_o == ADDR_W'($past(car_o) + 1'b1));  // R5
  AST_MAP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (start && !load_en) |=> (valid_o && car_o == $past(map_addr)));  // R7
  AST_LOAD_STALL: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (!valid_o && $stable(car_o)));  // R8
endmodule

bind micro_sequencer seq_checker #(.ADDR_W(ADDR_W), .UOP_W(UOP_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .load_en (load_en),
  .start   (start),
  .map_addr(map_addr),
  .car_o   (car_o),
  .uop_o   (uop_o),
  .valid_o (valid_o),
  .taken_w (taken_w),
  .target_w(target_w)
);

// File: tb/tb_micro_sequencer.sv
module tb_micro_sequencer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        load_en;
  logic [11:0] load_addr;
  logic [29:0] load_word;
  logic        start;
  logic [11:0] map_addr;
  logic [7:0]  flags;
  logic [11:0] car_o;
  logic [14:0] uop_o;
  logic        valid_o;

  int checks = 0;
  int errors = 0;
  bit reported = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  micro_sequencer dut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
    .load_word(load_word), .start(start), .map_addr(map_addr),
    .flags(flags), .car_o(car_o), .uop_o(uop_o), .valid_o(valid_o)
  );

  function automatic logic [29:0] mk(input logic [14:0] u, input logic [2:0] s,
                                     input logic [11:0] t);
    return {u, s, t};
  endfunction

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // advance one edge; inputs change on the falling edge only
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_state(input string req, input logic [11:0] a,
                              input logic [14:0] u, input logic v);
    checks++;
    if (car_o !== a || uop_o !== u || valid_o !== v) begin
      errors++;
      $display("FAIL %s: car=%h uop=%h valid=%b expected car=%h uop=%h valid=%b",
               req, car_o, uop_o, valid_o, a, u, v);
    end
  endtask

  task automatic preload(input logic [11:0] a, input logic [29:0] w);
    load_en = 1'b1; load_addr = a; load_word = w;
    step();
    load_en = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; load_en = 1'b0; start = 1'b0; map_addr = '0; flags = '0;
    load_addr = '0; load_word = '0;
    step(); step();
    expect_state("R1 in reset", 12'h000, 15'h0, 1'b0);
    rst = 1'b0;
    expect_state("R1 after release", 12'h000, 15'h0, 1'b0);
  endtask

  task automatic t_preload_program();
    preload(12'h000, mk(15'h0011, 3'd2, 12'h100));
    preload(12'h001, mk(15'h0022, 3'd5, 12'h200));
    preload(12'h002, mk(15'h7FFF, 3'd0, 12'h005));
    preload(12'h005, mk(15'h0001, 3'd6, 12'h100));
    preload(12'h100, mk(15'h4001, 3'd7, 12'hFFF));
    preload(12'hFFF, mk(15'h1234, 3'd1, 12'h000));
    preload(12'h300, mk(15'h5555, 3'd3, 12'h010));
    preload(12'h301, mk(15'h2AAA, 3'd4, 12'h020));
    expect_state("R8 held during preload", 12'h000, 15'h0, 1'b0);
  endtask

  task automatic t_prime_and_seq();
    flags = 8'h00;
    step();
    expect_state("R3 prime at 0", 12'h000, 15'h0011, 1'b1);
    step();
    expect_state("R5 flag clear steps", 12'h001, 15'h0022, 1'b1);
    flags = 8'hDF;  // every flag but the selected bit 5
    step();
    expect_state("R9 other flags ignored", 12'h002, 15'h7FFF, 1'b1);
    expect_state("R2 full field", 12'h002, 15'h7FFF, 1'b1);
  endtask

  task automatic t_branches_and_wrap();
    flags = 8'h01;
    step();
    expect_state("R4 branch on flag 0", 12'h005, 15'h0001, 1'b1);
    flags = 8'h40;
    step();
    expect_state("R4 branch on flag 6", 12'h100, 15'h4001, 1'b1);
    flags = 8'h80;
    step();
    expect_state("R4 branch to top", 12'hFFF, 15'h1234, 1'b1);
    flags = 8'hFD;  // selected bit 1 clear
    step();
    expect_state("R6 wrap to 0", 12'h000, 15'h0011, 1'b1);
  endtask

  task automatic t_start();
    flags = 8'h04;  // word 0 would branch to 0x100
    start = 1'b1; map_addr = 12'h300;
    step();
    start = 1'b0; flags = 8'h00;
    expect_state("R7 start over branch", 12'h300, 15'h5555, 1'b1);
    step();
    expect_state("R5 step after entry", 12'h301, 15'h2AAA, 1'b1);
  endtask

  task automatic t_load_midrun();
    start = 1'b1; map_addr = 12'h000;
    preload(12'h301, mk(15'h0F0F, 3'd4, 12'h020));
    start = 1'b0;
    expect_state("R8 start ignored while loading", 12'h301, 15'h0, 1'b0);
    flags = 8'h10;
    step();
    expect_state("R3 refetch shows new word", 12'h301, 15'h0F0F, 1'b1);
    step();
    expect_state("R4 branch from rewritten word", 12'h020, uop_o, 1'b1);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    report();
  end

  initial begin
    t_reset();
    t_preload_program();
    t_prime_and_seq();
    t_branches_and_wrap();
    t_start();
    t_load_midrun();
    report();
  end
endmodule